// File: doc/BRIEF.md
# Multi-channel DMA channel controller

This block keeps the control state of eight DMA channels and arbitrates nothing: it takes one device transfer request at a time, vets it against the addressed channel's setup, and either issues a single memory burst command or flags an error. Each request names a channel, a direction (memory-to-device or device-to-memory) and a byte length.

A request passes only when its channel is enabled and the channel's configured direction matches the request. A passing request produces one burst command carrying the channel's address register and a length equal to the smaller of the requested length and the channel's remaining byte count. When the downstream side accepts the command, the terminal-count flag is set and the count shrinks by that length; the address register is left alone. A failing request produces no command. Instead it sets the channel's memory-error flag and the channel's bit in a shared non-maskable error source register. Software reads and writes the channel registers over a simple register port. Writes that land while a request is in flight are held and applied once it finishes.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset every channel register reads 0, the error source register reads 0, `nmi_pending` is 0 and `req_busy` is 0.
- R2: Channel n register k (k=0 mode, 1 flags, 2 byte count, 3 address) is at byte offset 0x100 + n*0x20 + k*8. A write to it is read back unchanged. Any other offset, including a channel offset whose bits [2:0] are not zero, reads 0 and ignores writes.
- R3: The error source register at offset 0x200 holds bit n for channel n. Writes to it are ignored. Its bits only get set and stay set until reset. `nmi_pending` is the OR of its bits.
- R4: A request is taken on a clock edge where `req_valid` is high and `req_busy` is low. `req_busy` stays high until the completing cycle. A `req_valid` seen while busy is dropped with no effect.
- R5: A request succeeds when flags bit 0 (enable) is 1 and flags bit 1 (1 = memory-to-device) equals `req_to_dev`. It then raises `mem_cmd_valid` with the channel's address register, a length of min(`req_len`, count) and `mem_cmd_to_dev` equal to the request direction. These stay steady until `mem_cmd_ready`.
- R6: When the command is accepted, flags bit 8 (terminal count) is set, the count drops by the issued length, and the address register is unchanged. `req_done` pulses with `req_ok` = 1.
- R7: A request on a disabled channel, or one whose direction disagrees with flags bit 1, issues no command. It sets flags bit 9 (memory error) and error source bit n, and `req_done` pulses with `req_ok` = 0.
- R8: Taking a request first clears flags bits 8, 9 and 10 of that channel. The other flag bits are kept.
- R9: A register write made while `req_busy` is high leaves the register unchanged until the request completes, then takes effect, winning over the count and flag update. Only the last such write per request is kept.
- R10: `req_done` is a single-cycle pulse, and `mem_cmd_valid` is only high while `req_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Transfer request strobe |
| req_chan | input | $clog2(NCH) | Requested channel |
| req_to_dev | input | 1 | 1 = memory-to-device, 0 = device-to-memory |
| req_len | input | 32 | Requested byte length |
| req_busy | output | 1 | A request is in progress |
| req_done | output | 1 | Request finished (one-cycle pulse) |
| req_ok | output | 1 | Outcome of the finished request, valid with `req_done` |
| mem_cmd_valid | output | 1 | Burst command offered |
| mem_cmd_ready | input | 1 | Burst command accepted |
| mem_cmd_addr | output | 32 | Burst start address |
| mem_cmd_len | output | 32 | Burst byte length |
| mem_cmd_to_dev | output | 1 | Burst direction |
| nmi_src | output | NCH | Per-channel error source bits |
| nmi_pending | output | 1 | Any error source bit set |

## Verification
The passing path is tried with a requested length below the count, above the count, and against a count of zero. Together these separate clipping to the count from passing the request through, and show that a zero-length burst still completes.

Both directions are tried. One burst is held off by the downstream side for several cycles, which shows that the command stays steady and the count is not touched early.

The failing path is tried twice: once with the channel disabled and once with a direction mismatch. A software-set error flag and a stale terminal-count flag show that flags are cleared at the start of each request.

A final scenario overlaps a second request and two register writes with a stalled burst. It separates dropping the request, deferring the writes, and keeping only the last write.

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int NCH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [9:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic                   req_valid,
  input  logic [$clog2(NCH)-1:0] req_chan,
  input  logic                   req_to_dev,
  input  logic [31:0]            req_len,
  output logic                   req_busy,
  output logic                   req_done,
  output logic                   req_ok,
  output logic                   mem_cmd_valid,
  input  logic                   mem_cmd_ready,
  output logic [31:0]            mem_cmd_addr,
  output logic [31:0]            mem_cmd_len,
  output logic                   mem_cmd_to_dev,
  output logic [NCH-1:0]         nmi_src,
  output logic                   nmi_pending
);
  localparam int CHW  = $clog2(NCH);
  localparam int NREG = NCH * 4;
  localparam int RIW  = CHW + 2;
  localparam logic [31:0] F_EN    = 32'h0000_0001;
  localparam logic [31:0] F_TODEV = 32'h0000_0002;
  localparam logic [31:0] F_TC    = 32'h0000_0100;
  localparam logic [31:0] F_MERR  = 32'h0000_0200;
  localparam logic [31:0] F_STAT  = 32'h0000_0700;

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_CMD} state_t;

  state_t           state;
  logic [31:0]      regs [NREG];
  logic [CHW-1:0]   cur_ch;
  logic             cur_dir;
  logic [31:0]      cur_len;
  logic [31:0]      xfer_len;
  logic             pend_v;
  logic [RIW-1:0]   pend_idx;
  logic [31:0]      pend_data;

  wire             ch_hit  = (reg_addr[9:8] == 2'b01) && (reg_addr[2:0] == 3'b000)
                             && (int'(reg_addr[7:5]) < NCH);
  wire             nmi_hit = (reg_addr == 10'h200);
  wire [RIW-1:0]   reg_idx = {reg_addr[5 +: CHW], reg_addr[4:3]};
  wire             wr_hit  = reg_we && ch_hit;

  wire [RIW-1:0]   i_flag  = {cur_ch, 2'd1};
  wire [RIW-1:0]   i_cnt   = {cur_ch, 2'd2};
  wire [RIW-1:0]   i_addr  = {cur_ch, 2'd3};
  wire [RIW-1:0]   i_rflag = {req_chan, 2'd1};

  wire [31:0]      flags   = regs[i_flag];
  wire [31:0]      count   = regs[i_cnt];
  wire             chan_ok = ((flags & F_EN) != 0) && (((flags & F_TODEV) != 0) == cur_dir);
  wire             fin     = (state == S_EVAL && !chan_ok) || (state == S_CMD && mem_cmd_ready);
  wire [31:0]      rflag_now = (wr_hit && reg_idx == i_rflag) ? reg_wdata : regs[i_rflag];

  assign reg_rdata      = ch_hit ? regs[reg_idx] : (nmi_hit ? 32'(nmi_src) : 32'h0);
  assign req_busy       = (state != S_IDLE);
  assign mem_cmd_valid  = (state == S_CMD);
  assign mem_cmd_addr   = regs[i_addr];
  assign mem_cmd_len    = xfer_len;
  assign mem_cmd_to_dev = cur_dir;
  assign nmi_pending    = |nmi_src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      state     <= S_IDLE;
      nmi_src   <= '0;
      cur_ch    <= '0;
      cur_dir   <= 1'b0;
      cur_len   <= '0;
      xfer_len  <= '0;
      pend_v    <= 1'b0;
      pend_idx  <= '0;
      pend_data <= '0;
      req_done  <= 1'b0;
      req_ok    <= 1'b0;
    end else begin
      req_done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (wr_hit) regs[reg_idx] <= reg_wdata;
          if (req_valid) begin
            regs[i_rflag] <= rflag_now & ~F_STAT;
            cur_ch  <= req_chan;
            cur_dir <= req_to_dev;
            cur_len <= req_len;
            state   <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (chan_ok) begin
            xfer_len <= (cur_len < count) ? cur_len : count;
            state    <= S_CMD;
          end else begin
            regs[i_flag]    <= flags | F_MERR;
            nmi_src[cur_ch] <= 1'b1;
            req_done        <= 1'b1;
            req_ok          <= 1'b0;
            state           <= S_IDLE;
          end
        end
        S_CMD: begin
          if (mem_cmd_ready) begin
            regs[i_flag] <= flags | F_TC;
            regs[i_cnt]  <= count - xfer_len;
            req_done     <= 1'b1;
            req_ok       <= 1'b1;
            state        <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (state != S_IDLE) begin
        if (fin) begin
          if (pend_v) regs[pend_idx] <= pend_data;
          if (wr_hit) regs[reg_idx] <= reg_wdata;
          pend_v <= 1'b0;
        end else if (wr_hit) begin
          pend_v    <= 1'b1;
          pend_idx  <= reg_idx;
          pend_data <= reg_wdata;
        end
      end
    end
  end
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_busy,
  input logic           req_done,
  input logic           mem_cmd_valid,
  input logic           mem_cmd_ready,
  input logic [31:0]    mem_cmd_addr,
  input logic [31:0]    mem_cmd_len,
  input logic [NCH-1:0] nmi_src,
  input logic [31:0]    cur_len
);
  assert_take_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_busy |=> req_busy);

  assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_ready |=> mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_len));

  assert_cmd_clip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> mem_cmd_len <= cur_len);

  assert_nmi_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((nmi_src & $past(nmi_src)) == $past(nmi_src)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  assert_cmd_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> req_busy);
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_busy(req_busy),
  .req_done(req_done), .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
  .mem_cmd_addr(mem_cmd_addr), .mem_cmd_len(mem_cmd_len), .nmi_src(nmi_src),
  .cur_len(cur_len)
);

// File: tb/dma_chan_ctrl_tb.sv
module dma_chan_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [9:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        req_valid = 0;
  logic [2:0]  req_chan = 0;
  logic        req_to_dev = 0;
  logic [31:0] req_len = 0;
  logic        req_busy, req_done, req_ok;
  logic        mem_cmd_valid, mem_cmd_ready = 1, mem_cmd_to_dev;
  logic [31:0] mem_cmd_addr, mem_cmd_len;
  logic [NCH-1:0] nmi_src;
  logic        nmi_pending;

  int checks = 0, errors = 0;

  dma_chan_ctrl #(.NCH(NCH)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] ra(input int ch, input int k);
    return 10'(32'h100 + ch * 32'h20 + k * 8);
  endfunction

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic run_req(input int ch, input logic dir, input logic [31:0] len, input int hold,
                         output logic ok, output logic seen, output logic [31:0] caddr,
                         output logic [31:0] clen, output logic cdir);
    int waited = 0;
    logic got = 0;
    seen = 0; ok = 0; caddr = 0; clen = 0; cdir = 0;
    @(negedge clk);
    req_valid = 1; req_chan = 3'(ch); req_to_dev = dir; req_len = len;
    mem_cmd_ready = (hold == 0);
    for (int i = 0; i < 40 && !got; i++) begin
      @(negedge clk);
      req_valid = 0;
      if (mem_cmd_valid) begin
        if (seen) begin
          check("R5 cmd addr held", mem_cmd_addr, caddr);
          check("R5 cmd len held", mem_cmd_len, clen);
        end
        seen = 1; caddr = mem_cmd_addr; clen = mem_cmd_len; cdir = mem_cmd_to_dev;
        waited++;
        if (waited >= hold) mem_cmd_ready = 1;
      end
      if (req_done) begin
        got = 1; ok = req_ok;
        @(negedge clk);
        check("R10 done single pulse", 32'(req_done), 0);
      end
    end
    check("R4 request completed", 32'(got), 1);
    mem_cmd_ready = 1;
  endtask

  task automatic t_reset;
    rd_chk("R1 mode reset", ra(0, 0), 0);
    rd_chk("R1 flags reset", ra(3, 1), 0);
    rd_chk("R1 count reset", ra(7, 2), 0);
    rd_chk("R1 nmi reset", 10'h200, 0);
    check("R1 busy reset", 32'(req_busy), 0);
    check("R1 pending reset", 32'(nmi_pending), 0);
  endtask

  task automatic t_regmap;
    for (int k = 0; k < 4; k++) begin
      wr(ra(0, k), 32'hA0 + 32'(k));
      wr(ra(7, k), 32'hC0DE_0070 + 32'(k));
    end
    for (int k = 0; k < 4; k++) begin
      rd_chk("R2 ch0 readback", ra(0, k), 32'hA0 + 32'(k));
      rd_chk("R2 ch7 readback", ra(7, k), 32'hC0DE_0070 + 32'(k));
    end
    wr(ra(4, 0) + 10'd4, 32'hDEAD);
    rd_chk("R2 misaligned reads 0", ra(4, 0) + 10'd4, 0);
    rd_chk("R2 misaligned write ignored", ra(4, 0), 0);
    wr(10'h000, 32'h1234);
    rd_chk("R2 unmapped reads 0", 10'h000, 0);
    for (int k = 0; k < 4; k++) begin
      wr(ra(0, k), 0);
      wr(ra(7, k), 0);
    end
  endtask

  task automatic t_success;
    logic ok, seen, cdir; logic [31:0] ca, cl;
    wr(ra(2, 1), 32'h1); wr(ra(2, 2), 100); wr(ra(2, 3), 32'hA000);
    run_req(2, 0, 40, 0, ok, seen, ca, cl, cdir);
    check("R5 ok", 32'(ok), 1);
    check("R5 cmd seen", 32'(seen), 1);
    check("R5 cmd addr", ca, 32'hA000);
    check("R5 cmd len short", cl, 40);
    check("R5 cmd dir", 32'(cdir), 0);
    rd_chk("R6 count reduced", ra(2, 2), 60);
    rd_chk("R6 tc set", ra(2, 1), 32'h101);
    rd_chk("R6 addr unchanged", ra(2, 3), 32'hA000);
    run_req(2, 0, 100, 0, ok, seen, ca, cl, cdir);
    check("R5 len clipped to count", cl, 60);
    rd_chk("R6 count zero", ra(2, 2), 0);
    run_req(2, 0, 5, 0, ok, seen, ca, cl, cdir);
    check("R5 zero count ok", 32'(ok), 1);
    check("R5 zero length cmd", cl, 0);
    rd_chk("R6 count stays zero", ra(2, 2), 0);
  endtask

  task automatic t_to_dev_stall;
    logic ok, seen, cdir; logic [31:0] ca, cl;
    wr(ra(5, 1), 32'h3); wr(ra(5, 2), 16); wr(ra(5, 3), 32'h8000_0040);
    run_req(5, 1, 16, 4, ok, seen, ca, cl, cdir);
    check("R5 to-dev ok", 32'(ok), 1);
    check("R5 to-dev dir", 32'(cdir), 1);
    check("R5 to-dev addr", ca, 32'h8000_0040);
    rd_chk("R6 to-dev count", ra(5, 2), 0);
    rd_chk("R6 to-dev flags", ra(5, 1), 32'h103);
  endtask

  task automatic t_fail;
    logic ok, seen, cdir; logic [31:0] ca, cl;
    run_req(5, 0, 8, 0, ok, seen, ca, cl, cdir);
    check("R7 dir mismatch fails", 32'(ok), 0);
    check("R7 no cmd on mismatch", 32'(seen), 0);
    rd_chk("R8 tc cleared, R7 merr set", ra(5, 1), 32'h203);
    rd_chk("R3 nmi bit5", 10'h200, 32'h20);
    check("R3 pending", 32'(nmi_pending), 1);
    wr(ra(1, 1), 32'h400); wr(ra(1, 2), 10);
    run_req(1, 0, 4, 0, ok, seen, ca, cl, cdir);
    check("R7 disabled fails", 32'(ok), 0);
    check("R7 no cmd disabled", 32'(seen), 0);
    rd_chk("R8 addr-err cleared", ra(1, 1), 32'h200);
    rd_chk("R7 count untouched", ra(1, 2), 10);
    rd_chk("R3 nmi bits 1 and 5", 10'h200, 32'h22);
    wr(ra(1, 1), 32'h601);
    run_req(1, 0, 4, 0, ok, seen, ca, cl, cdir);
    check("R5 re-enabled ok", 32'(ok), 1);
    rd_chk("R8 stale error bits cleared", ra(1, 1), 32'h101);
    rd_chk("R3 nmi sticky", 10'h200, 32'h22);
    wr(10'h200, 0);
    rd_chk("R3 nmi write ignored", 10'h200, 32'h22);
  endtask

  task automatic t_busy;
    logic [31:0] d;
    wr(ra(2, 1), 32'h1); wr(ra(2, 2), 50); wr(ra(2, 3), 32'h1234);
    @(negedge clk);
    req_valid = 1; req_chan = 2; req_to_dev = 0; req_len = 10; mem_cmd_ready = 0;
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    check("R5 cmd offered", 32'(mem_cmd_valid), 1);
    req_valid = 1; req_chan = 3; req_to_dev = 0; req_len = 1;
    reg_we = 1; reg_addr = ra(6, 0); reg_wdata = 32'h77;
    @(negedge clk);
    req_valid = 0; reg_addr = ra(2, 2); reg_wdata = 32'h55;
    @(negedge clk);
    reg_we = 0;
    rd(ra(2, 2), d);
    check("R9 write deferred", d, 50);
    check("R4 still busy", 32'(req_busy), 1);
    mem_cmd_ready = 1;
    @(negedge clk);
    check("R6 done", 32'(req_done), 1);
    check("R6 ok", 32'(req_ok), 1);
    rd_chk("R9 deferred write wins", ra(2, 2), 32'h55);
    rd_chk("R9 earlier write dropped", ra(6, 0), 0);
    rd_chk("R6 flags after", ra(2, 1), 32'h101);
    rd_chk("R4 busy request dropped", 10'h200, 32'h22);
    rd_chk("R4 ch3 flags untouched", ra(3, 1), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_regmap;
    t_success;
    t_to_dev_stall;
    t_fail;
    t_busy;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule